// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K bytes. The host hands it one byte access at a time over a valid/ready handshake: a read returns the byte through a one-cycle response pulse, and a write drives the byte into the memory. On the memory side the block produces a 19-bit address, an 8-bit data bus split into output, input and driver-enable, an active-low and an active-high chip select, an active-low output enable and an active-low write strobe.

Every phase length comes from a nanosecond limit divided by the clock period `CLK_PERIOD_NS` and rounded up, with at least one cycle per phase. The write strobe covers the pulse width, the select-to-end-of-write time, and the memory's bus release plus the data setup time. Between accesses, both chip selects are inactive, so the memory rests in its low-power standby. The numbers below are for the default 5 ns clock.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1, `rsp_valid`=0 and `rsp_rdata`=0. A reset in the middle of a write ends the access at once.
- R2: Whenever the block is idle (`req_ready`=1), the memory is in standby: `mem_ce_n`=1 and `mem_ce`=0.
- R3: A read accepted at edge E0 holds `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_addr` equal to the request address from E0 until E0+RD, where RD = ceil(max(70 ns read cycle, 70 ns access) / period) = 14. The data bus is sampled at E0+RD.
- R4: After a read, `rsp_valid` is high for exactly one cycle, starting at E0+RD, with `rsp_rdata` set to the sampled byte. `rsp_rdata` changes only together with a `rsp_valid` pulse.
- R5: A write accepted at E0 pulls `mem_we_n` low from E0 for WE = max(ceil(55/T), ceil(60/T), ceil(25/T)+ceil(30/T)) = 12 cycles. `mem_oe_n` stays high for the whole write.
- R6: The data driver `mem_dq_oe` rises ceil(25/T) = 5 cycles after `mem_we_n` falls. It carries the request byte unchanged on `mem_dq_out` for the remaining 7 strobe cycles and drops in the same cycle that `mem_we_n` rises.
- R7: The selects stay active for ceil(70/T) = 14 cycles of a write. The strobe then stays high for the last 2 of them, and one deselected cycle with `req_ready`=0 follows before the block is idle again.
- R8: `req_ready` is high only while idle, and a request is accepted on an edge where `req_valid` and `req_ready` are both high. A request held valid while busy leaves the running access untouched and is accepted on the first idle edge.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low or `mem_we_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 8 | Last byte read, held |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_ce | output | 1 | Memory select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Driver enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
A phase counter that expires one cycle early or late shows up on the strobes in that same access. A read then samples the bus before the memory model has settled and returns a garbage byte, and a write changes the strobe width or the data setup window seen at the strobe's rising edge. A wrong state decode shows up within the cycle as a driver enabled against the output enable, selects left active while idle, or a missing turnaround cycle, which moves the return of `req_ready` off cycle 16.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WLOW,
    ST_WREC,
    ST_TURN
  } sram_state_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } sram_pins_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int strobe_cycles(input int wp, input int cw, input int whz,
                                       input int ds, input int period);
    return max2(max2(ns_to_cyc(wp, period), ns_to_cyc(cw, period)),
                ns_to_cyc(whz, period) + ns_to_cyc(ds, period));
  endfunction

  function automatic int recovery_cycles(input int wc, input int strobe, input int period);
    int c;
    c = ns_to_cyc(wc, period) - strobe;
    return (c < 0) ? 0 : c;
  endfunction

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nx,
  output logic             expire
);

  assign count_nx = (restart || !run) ? '0 : count + 1'b1;
  assign expire   = (count == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nx;
  end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              valid,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= capture;
      if (capture) data <= din;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 55,
  parameter int T_CW_NS       = 60,
  parameter int T_DS_NS       = 30,
  parameter int T_WHZ_NS      = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC  = max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_AA_NS, CLK_PERIOD_NS));
  localparam int WE_CYC  = strobe_cycles(T_WP_NS, T_CW_NS, T_WHZ_NS, T_DS_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = recovery_cycles(T_WC_NS, WE_CYC, CLK_PERIOD_NS);
  localparam int WHZ_CYC = ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = max2(max2(RD_CYC, WE_CYC), REC_CYC + 1);
  localparam int CNT_W   = cnt_width(MAX_CYC);

  localparam sram_pins_t PINS_IDLE = '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  sram_state_e      state, state_nx;
  logic [CNT_W-1:0] phase_lim, phase_cnt, phase_cnt_nx;
  logic             phase_done, restart, run;
  sram_pins_t       pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // named internal events, observed by the bound checker
  logic accept_evt, capture_evt, we_release_evt;

  assign accept_evt     = (state == ST_IDLE) && req_valid;
  assign capture_evt    = (state == ST_READ) && phase_done;
  assign we_release_evt = (state == ST_WLOW) && phase_done;

  // strobe levels for a given phase and position inside it
  function automatic sram_pins_t pins_for(input sram_state_e st, input logic [CNT_W-1:0] c);
    sram_pins_t p;
    p = PINS_IDLE;
    case (st)
      ST_READ: begin p.ce_n = 1'b0; p.ce = 1'b1; p.oe_n = 1'b0; end
      ST_WLOW: begin
        p.ce_n  = 1'b0; p.ce = 1'b1; p.we_n = 1'b0;
        p.dq_oe = (c >= CNT_W'(WHZ_CYC));
      end
      ST_WREC: begin p.ce_n = 1'b0; p.ce = 1'b1; end
      default: p = PINS_IDLE;
    endcase
    return p;
  endfunction

  always_comb begin
    case (state)
      ST_READ: phase_lim = CNT_W'(RD_CYC);
      ST_WLOW: phase_lim = CNT_W'(WE_CYC);
      ST_WREC: phase_lim = CNT_W'(max2(REC_CYC, 1));
      default: phase_lim = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept_evt) state_nx = req_write ? ST_WLOW : ST_READ;
      ST_READ: if (phase_done) state_nx = ST_IDLE;
      ST_WLOW: if (phase_done) state_nx = (REC_CYC > 0) ? ST_WREC : ST_TURN;
      ST_WREC: if (phase_done) state_nx = ST_TURN;
      ST_TURN: if (phase_done) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  assign restart = (state_nx != state);
  assign run     = (state_nx != ST_IDLE);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .run      (run),
    .limit    (phase_lim),
    .count    (phase_cnt),
    .count_nx (phase_cnt_nx),
    .expire   (phase_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pins_q  <= PINS_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state  <= state_nx;
      pins_q <= pins_for(state_nx, phase_cnt_nx);
      if (accept_evt) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  sram_read_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture_evt),
    .din     (mem_dq_in),
    .valid   (rsp_valid),
    .data    (rsp_rdata)
  );

  assign req_ready  = (state == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = pins_q.ce_n;
  assign mem_ce     = pins_q.ce;
  assign mem_oe_n   = pins_q.oe_n;
  assign mem_we_n   = pins_q.we_n;
  assign mem_dq_oe  = pins_q.dq_oe;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int RD_CYC = 14,
  parameter int WE_CYC = 12,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic              accept_evt,
  input logic              capture_evt,
  input logic              we_release_evt
);

  int unsigned rd_cnt;
  int unsigned we_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= 0;
      we_cnt <= 0;
    end else begin
      rd_cnt <= !mem_oe_n ? rd_cnt + 1 : 0;
      we_cnt <= !mem_we_n ? we_cnt + 1 : 0;
    end
  end

  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce)); // R2

  AST_READ_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_ce && mem_we_n)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R3

  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (rd_cnt == RD_CYC - 1)); // R3

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_valid); // R4

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_cnt == WE_CYC)); // R5

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R5

  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R6

  AST_RELEASE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    we_release_evt |=> (mem_we_n && !mem_dq_oe)); // R6

  AST_WRITE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n) && $past(mem_oe_n)) |-> !req_ready); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready); // R8

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R9

endmodule

bind sram_ctrl sram_ctrl_checker #(
  .RD_CYC (RD_CYC),
  .WE_CYC (WE_CYC),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  localparam int PER = 5;
  // own restatement of the timing: whole cycles that cover each limit
  function automatic int cyc(input int ns);
    return ns / PER + ((ns % PER) != 0 ? 1 : 0);
  endfunction
  localparam int RD_CYC  = cyc(70);
  localparam int WHZ_CYC = cyc(25);
  localparam int WE_CYC  = (cyc(60) > cyc(25) + cyc(30)) ? cyc(60) : cyc(25) + cyc(30);
  localparam int WR_SEL  = cyc(70);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #2.5 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: data is valid only after a full access time with a steady address
  logic [7:0]  mem_model [256];
  logic [7:0]  exp_mem   [256];
  int          rd_age = 0;
  logic [18:0] rd_addr_prev = '0;
  assign mem_dq_in = (rd_age >= RD_CYC) ? mem_model[mem_addr[7:0]] : 8'hEE;

  int          we_low = 0, drv = 0, drv_start = 0, oe_bad_w = 0;
  logic [7:0]  drv_data = '0;
  int          wr_events = 0;
  logic [18:0] last_wr_addr = '0;
  logic [7:0]  last_wr_data = '0;
  int          contention = 0, standby_bad = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_model[i] = 8'(i) ^ 8'h5A;
      exp_mem[i]   = 8'(i) ^ 8'h5A;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_age = 0; we_low = 0; drv = 0; drv_start = 0; oe_bad_w = 0;
    end else begin
      if (mem_dq_oe && (mem_we_n || !mem_oe_n)) contention++;
      if (req_ready && (!mem_ce_n || mem_ce)) standby_bad++;
      if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) begin
        rd_age = (rd_age > 0 && mem_addr == rd_addr_prev) ? rd_age + 1 : 1;
        rd_addr_prev = mem_addr;
      end else rd_age = 0;
      if (!mem_ce_n && mem_ce && !mem_we_n) begin
        we_low++;
        if (!mem_oe_n) oe_bad_w++;
        if (mem_dq_oe) begin
          if (drv == 0) drv_start = we_low;
          if (drv > 0 && mem_dq_out != drv_data) drv = 1;
          else drv++;
          drv_data = mem_dq_out;
        end
      end else if (we_low > 0) begin
        chk(we_low == WE_CYC, "R5 strobe width", we_low, WE_CYC);
        chk(oe_bad_w == 0, "R5 oe high during write", oe_bad_w, 0);
        chk(drv_start == WHZ_CYC + 1, "R6 driver start", drv_start, WHZ_CYC + 1);
        chk(drv == WE_CYC - WHZ_CYC, "R6 stable drive cycles", drv, WE_CYC - WHZ_CYC);
        chk(!mem_dq_oe, "R6 release with strobe", mem_dq_oe, 0);
        mem_model[mem_addr[7:0]] = drv_data;
        last_wr_addr = mem_addr;
        last_wr_data = drv_data;
        wr_events++;
        we_low = 0; drv = 0; drv_start = 0; oe_bad_w = 0;
      end
    end
  end

  logic [7:0] prev_rdata = '0;

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int n, sel, ev0;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    ev0 = wr_events;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_ce_n && mem_ce && !mem_we_n && mem_oe_n && mem_addr == a,
        "R5 write start pins", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n}, 4'b0101);
    n = 1; sel = 1;
    while (!req_ready && n < 40) begin
      @(negedge clk);
      n++;
      if (!mem_ce_n && mem_ce) sel++;
      if (n == WR_SEL + 1)
        chk(mem_ce_n && !mem_ce && !req_ready, "R7 turnaround cycle",
            {mem_ce_n, mem_ce, req_ready}, 3'b100);
    end
    chk(n == WR_SEL + 2, "R7 ready return cycle", n, WR_SEL + 2);
    chk(sel == WR_SEL, "R7 selected cycles", sel, WR_SEL);
    chk(wr_events == ev0 + 1 && last_wr_addr == a && last_wr_data == d,
        "R6 written byte", {last_wr_addr, last_wr_data}, {a, d});
    exp_mem[a[7:0]] = d;
  endtask

  task automatic do_read(input logic [18:0] a);
    int n;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n && mem_addr == a,
        "R3 read pins", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n}, 4'b0101);
    chk(rsp_rdata == prev_rdata, "R4 data held", rsp_rdata, prev_rdata);
    n = 1;
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n == RD_CYC + 1, "R3 capture cycle", n, RD_CYC + 1);
    chk(rsp_rdata == exp_mem[a[7:0]], "R4 read data", rsp_rdata, exp_mem[a[7:0]]);
    chk(req_ready, "R8 ready after read", req_ready, 1);
    @(negedge clk);
    chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
    chk(rsp_rdata == exp_mem[a[7:0]], "R4 data stays", rsp_rdata, exp_mem[a[7:0]]);
    prev_rdata = exp_mem[a[7:0]];
  endtask

  // {write, addr[18:0], data[7:0]}
  localparam logic [27:0] VEC [12] = '{
    {1'b1, 19'h00011, 8'h3C},
    {1'b0, 19'h00011, 8'h00},
    {1'b0, 19'h7FF22, 8'h00},
    {1'b1, 19'h7FF22, 8'hFF},
    {1'b0, 19'h7FF22, 8'h00},
    {1'b1, 19'h40033, 8'h00},
    {1'b1, 19'h00044, 8'hA5},
    {1'b0, 19'h40033, 8'h00},
    {1'b0, 19'h00044, 8'h00},
    {1'b1, 19'h00011, 8'h81},
    {1'b0, 19'h00011, 8'h00},
    {1'b0, 19'h00055, 8'h00}
  };

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int bad_we, bad_rdy, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready
        && !rsp_valid && rsp_rdata == 8'h00, "R1 reset pins",
        {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 7'b1011010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && !mem_ce && req_ready, "R2 standby after reset", {mem_ce_n, mem_ce}, 2'b10);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][27]) do_write(VEC[i][26:8], VEC[i][7:0]);
      else            do_read(VEC[i][26:8]);
    end

    // R8: request held valid while a read is running
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00022;
    @(negedge clk);
    req_write = 1'b1; req_addr = 19'h00066; req_wdata = 8'h77;
    bad_we = 0; bad_rdy = 0; n = 1;
    if (!mem_we_n) bad_we++;
    while (!rsp_valid && n < 40) begin
      if (req_ready) bad_rdy++;
      @(negedge clk);
      n++;
      if (!mem_we_n) bad_we++;
    end
    chk(bad_we == 0 && bad_rdy == 0, "R8 busy request ignored", bad_we + bad_rdy, 0);
    chk(rsp_rdata == exp_mem[8'h22], "R8 read unaffected", rsp_rdata, exp_mem[8'h22]);
    @(negedge clk);
    chk(!mem_we_n && mem_addr == 19'h00066, "R8 pending request taken",
        {mem_we_n, mem_addr}, {1'b0, 19'h00066});
    req_valid = 1'b0;
    wait_ready();
    exp_mem[8'h66] = 8'h77;
    prev_rdata = exp_mem[8'h22];
    do_read(19'h00066);

    // R1: reset in the middle of a write
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00077; req_wdata = 8'h12;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && !mem_ce && mem_we_n && !mem_dq_oe && req_ready && rsp_rdata == 8'h00,
        "R1 reset aborts write", {mem_ce_n, mem_ce, mem_we_n, mem_dq_oe, req_ready}, 5'b10101);
    @(negedge clk);
    rst_n = 1'b1;
    prev_rdata = 8'h00;
    do_read(19'h00044);

    repeat (3) @(negedge clk);
    chk(contention == 0, "R9 no driver against memory", contention, 0);
    chk(standby_bad == 0, "R2 standby while idle", standby_bad, 0);
    finish_run();
  end

endmodule